// File: doc/BRIEF.md
# Configurable Routed I/O Cell

This block is a single cell of a programmable I/O routing fabric. A 4:1 data multiplexer picks one of four routed signals. Its two select lines are decoded in Gray order, and each line comes from either of two routed select sources with its own inversion. A storage element follows the multiplexer. Static configuration makes it an edge-triggered register or a flow-through latch. The same configuration places it in the output path, places it in the input path, or bypasses it.

The storage clock comes from one of the global clocks or from a routed clock. Its polarity is programmable. The cell drives a pin value, a pin enable and a feedback signal back into the routing fabric. Output data polarity and enable polarity are programmed separately. All configuration inputs are static while the cell runs and change only while the cell is held in reset. An active-low reset clears the storage element. The reset is synchronous to the selected cell clock.

Top module: `iocell_route`

## Requirements
- R1: With `{s1,s0}` as the conditioned select code, `mux_data[0]` is picked for 00, `mux_data[1]` for 01, `mux_data[2]` for 11 and `mux_data[3]` for 10. In bypass mode the picked value reaches `pin_out` combinationally.
- R2: Select line s0 is taken from `sel_src[1]` when `cfg_sel0_src`=1, otherwise from `sel_src[0]`, and is inverted when `cfg_sel0_inv`=1. Select line s1 uses `cfg_sel1_src` and `cfg_sel1_inv` in the same way.
- R3: `pin_out` carries the internal output value inverted when `cfg_out_inv`=1 and unchanged when it is 0.
- R4: `pin_oe` equals `route_oe` when `cfg_oe_inv`=0 and its inverse when `cfg_oe_inv`=1.
- R5: In register mode (`cfg_latch`=0) on the output path (`cfg_in_path`=0, `cfg_bypass`=0), `pin_out` takes the multiplexer value present at each rising edge of the effective clock and holds it until the next such edge.
- R6: In latch mode (`cfg_latch`=1) the storage element follows its input while the effective clock is high and holds while it is low.
- R7: The effective clock is `gclk[i]` when `cfg_clk_src`=i and i < N_GCLK, otherwise `route_clk`, and it is inverted when `cfg_clk_inv`=1.
- R8: On the input path (`cfg_in_path`=1, `cfg_bypass`=0) the storage element captures `pin_in`, `fabric_fb` shows the stored value, and `pin_out` is driven combinationally from the multiplexer.
- R9: On the output path (`cfg_in_path`=0) `fabric_fb` equals the raw `pin_in`.
- R10: With `cfg_bypass`=1, `pin_out` is the multiplexer value (after output polarity) and `fabric_fb` equals `pin_in`, whatever the path setting.
- R11: While `rst_n` is low, the stored value becomes 0 at each active clock edge in register mode and during each transparent phase in latch mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset of the storage element, synchronous to the effective clock |
| mux_data | input | 4 | Routed data candidates for the 4:1 multiplexer |
| sel_src | input | 2 | Two routed select sources |
| pin_in | input | 1 | Value read back from the pin |
| gclk | input | N_GCLK | Dedicated global clocks |
| route_clk | input | 1 | Routed clock |
| route_oe | input | 1 | Routed output-enable control |
| cfg_latch | input | 1 | 1: flow-through latch, 0: edge-triggered register |
| cfg_in_path | input | 1 | 1: storage in input path, 0: in output path |
| cfg_bypass | input | 1 | 1: storage bypassed on the pin output |
| cfg_clk_src | input | CSW | Clock source index; values at or above N_GCLK pick route_clk |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_sel0_src | input | 1 | Source choice for select line s0 |
| cfg_sel1_src | input | 1 | Source choice for select line s1 |
| cfg_sel0_inv | input | 1 | Invert select line s0 |
| cfg_sel1_inv | input | 1 | Invert select line s1 |
| cfg_out_inv | input | 1 | Invert the pin output value |
| cfg_oe_inv | input | 1 | Invert the pin enable |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable |
| fabric_fb | output | 1 | Feedback signal into the routing fabric |

## Verification
The bound checker follows the cell on the edges of its own effective clock. On each rising edge it checks register capture on the output and input paths and the raw pin feedback on the output path and in bypass. On each falling edge it checks that an open latch has tracked the multiplexer. The Gray select order, the select-source and polarity options, the choice among all five clock sources and the reset clearing of both storage kinds depend on configuration. These are shown only by the bench scenarios, where a behavioural model receives random data and is compared with the pins in both phases of every clock.

// File: rtl/iocell_pkg.sv
// Package for the routed I/O cell: multiplexer size and the Gray-ordered
// select decode. Assumes exactly four data candidates.
package iocell_pkg;

    localparam int MUX_N = 4;
    localparam int MUX_SW = 2;

    // Select code values in Gray order, named after the input they pick
    typedef enum logic [MUX_SW-1:0] {
        PICK_0 = 2'b00,
        PICK_1 = 2'b01,
        PICK_2 = 2'b11,
        PICK_3 = 2'b10
    } pick_code_e;

    // Turn a Gray-ordered select code into a data index
    function automatic logic [MUX_SW-1:0] code_to_index(input logic [MUX_SW-1:0] code);
        logic [MUX_SW-1:0] idx;
        case (pick_code_e'(code))
            PICK_0:  idx = 2'd0;
            PICK_1:  idx = 2'd1;
            PICK_2:  idx = 2'd2;
            default: idx = 2'd3;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/iocell_selmux.sv
// Select conditioning and 4:1 data multiplexer.
// Each select line picks one of the routed select sources and applies its
// own polarity; the resulting code is decoded in Gray order.
// Assumes configuration inputs are static during operation.
module iocell_selmux
    import iocell_pkg::*;
(
    input  logic [MUX_N-1:0]  mux_data,
    input  logic [MUX_SW-1:0] sel_src,
    input  logic [MUX_SW-1:0] cfg_src,
    input  logic [MUX_SW-1:0] cfg_inv,
    output logic              mux_out
);

    logic [MUX_SW-1:0] sel_code;

    // One conditioning stage per select line
    for (genvar g = 0; g < MUX_SW; g++) begin : g_sel
        // Pick the source for this line and apply its polarity
        always_comb begin
            sel_code[g] = (cfg_src[g] ? sel_src[1] : sel_src[0]) ^ cfg_inv[g];
        end
    end

    // Route the candidate named by the decoded code
    always_comb begin
        mux_out = mux_data[code_to_index(sel_code)];
    end

endmodule

// File: rtl/iocell_clksel.sv
// Clock source selection for the cell storage element.
// Index values below N_GCLK pick a global clock; any larger value picks the
// routed clock. Assumes the selection changes only while the cell is in reset.
module iocell_clksel #(
    parameter int N_GCLK = 4,
    parameter int CSW    = $clog2(N_GCLK + 1)
) (
    input  logic [N_GCLK-1:0] gclk,
    input  logic              route_clk,
    input  logic [CSW-1:0]    cfg_clk_src,
    input  logic              cfg_clk_inv,
    output logic              eff_clk
);

    logic raw_clk;

    // Choose the clock source, routed clock by default
    always_comb begin
        raw_clk = route_clk;
        for (int i = 0; i < N_GCLK; i++) begin
            if (cfg_clk_src == CSW'(i)) begin
                raw_clk = gclk[i];
            end
        end
    end

    // Apply the programmed clock polarity
    always_comb begin
        eff_clk = raw_clk ^ cfg_clk_inv;
    end

endmodule

// File: rtl/iocell_store.sv
// Storage element of the cell: an edge-triggered register and a flow-through
// latch share one data input; the mode bit picks which one is visible.
// Reset is active low and acts with the effective clock: at the rising edge
// for the register, during the transparent phase for the latch.
module iocell_store (
    input  logic eff_clk,
    input  logic rst_n,
    input  logic latch_mode,
    input  logic d,
    output logic q
);

    logic q_ff;
    logic q_lat;

    // Register: capture or clear at the rising edge of the effective clock
    always_ff @(posedge eff_clk) begin
        if (!rst_n) begin
            q_ff <= 1'b0;
        end else begin
            q_ff <= d;
        end
    end

    // Latch: follow or clear while the effective clock is high
    always_latch begin
        if (eff_clk) begin
            q_lat <= rst_n ? d : 1'b0;
        end
    end

    // Expose the element chosen by configuration
    always_comb begin
        q = latch_mode ? q_lat : q_ff;
    end

endmodule

// File: rtl/iocell_route.sv
// Configurable routed I/O cell: Gray-decoded 4:1 multiplexer, storage element
// that can sit in the output path, the input path or be bypassed, selectable
// clock, and programmable polarities for output data and pin enable.
// Assumes all cfg_* inputs change only while rst_n is low.
module iocell_route #(
    parameter int N_GCLK = 4,
    localparam int CSW   = $clog2(N_GCLK + 1)
) (
    input  logic              rst_n,
    input  logic [3:0]        mux_data,
    input  logic [1:0]        sel_src,
    input  logic              pin_in,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              route_clk,
    input  logic              route_oe,
    input  logic              cfg_latch,
    input  logic              cfg_in_path,
    input  logic              cfg_bypass,
    input  logic [CSW-1:0]    cfg_clk_src,
    input  logic              cfg_clk_inv,
    input  logic              cfg_sel0_src,
    input  logic              cfg_sel1_src,
    input  logic              cfg_sel0_inv,
    input  logic              cfg_sel1_inv,
    input  logic              cfg_out_inv,
    input  logic              cfg_oe_inv,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fabric_fb
);

    logic mux_out;
    logic eff_clk;
    logic store_d;
    logic store_q;
    logic out_val;

    iocell_selmux u_selmux (
        .mux_data (mux_data),
        .sel_src  (sel_src),
        .cfg_src  ({cfg_sel1_src, cfg_sel0_src}),
        .cfg_inv  ({cfg_sel1_inv, cfg_sel0_inv}),
        .mux_out  (mux_out)
    );

    iocell_clksel #(
        .N_GCLK (N_GCLK),
        .CSW    (CSW)
    ) u_clksel (
        .gclk        (gclk),
        .route_clk   (route_clk),
        .cfg_clk_src (cfg_clk_src),
        .cfg_clk_inv (cfg_clk_inv),
        .eff_clk     (eff_clk)
    );

    // Storage input: pin on the input path, multiplexer on the output path
    always_comb begin
        store_d = cfg_in_path ? pin_in : mux_out;
    end

    iocell_store u_store (
        .eff_clk    (eff_clk),
        .rst_n      (rst_n),
        .latch_mode (cfg_latch),
        .d          (store_d),
        .q          (store_q)
    );

    // Pin value: stored only on the output path without bypass
    always_comb begin
        out_val = (cfg_bypass || cfg_in_path) ? mux_out : store_q;
    end

    // Apply output polarity, enable polarity and pick the feedback
    always_comb begin
        pin_out   = out_val ^ cfg_out_inv;
        pin_oe    = route_oe ^ cfg_oe_inv;
        fabric_fb = (cfg_in_path && !cfg_bypass) ? store_q : pin_in;
    end

endmodule

// File: rtl/iocell_route_chk.sv
// Checker for the routed I/O cell, clocked by the cell's effective clock.
// Bound to every instance of the top module below.
module iocell_route_chk (
    input logic eff_clk,
    input logic rst_n,
    input logic cfg_latch,
    input logic cfg_in_path,
    input logic cfg_bypass,
    input logic cfg_out_inv,
    input logic pin_in,
    input logic mux_out,
    input logic store_q,
    input logic pin_out,
    input logic fabric_fb
);

    // R5: register on the output path shows the value captured one edge earlier
    p_reg_capture_r5: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (!cfg_latch && !cfg_in_path && !cfg_bypass && $past(rst_n)
         && $past(!cfg_latch && !cfg_in_path && !cfg_bypass))
        |-> (pin_out == ($past(mux_out) ^ cfg_out_inv)));

    // R6: an open latch has tracked the multiplexer by the closing edge
    p_latch_follow_r6: assert property (@(negedge eff_clk) disable iff (!rst_n)
        (cfg_latch && !cfg_in_path && !cfg_bypass) |-> (store_q == mux_out));

    // R8: input-path register feeds the fabric with the pin captured an edge earlier
    p_inpath_fb_r8: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (!cfg_latch && cfg_in_path && !cfg_bypass && $past(rst_n)
         && $past(!cfg_latch && cfg_in_path && !cfg_bypass))
        |-> (fabric_fb == $past(pin_in)));

    // R9: output path returns the raw pin to the fabric
    p_outpath_fb_r9: assert property (@(posedge eff_clk) disable iff (!rst_n)
        (!cfg_in_path) |-> (fabric_fb == pin_in));

    // R10: bypass drives the pin from the multiplexer and feeds back the raw pin
    p_bypass_r10: assert property (@(posedge eff_clk) disable iff (!rst_n)
        cfg_bypass |-> ((fabric_fb == pin_in) && (pin_out == (mux_out ^ cfg_out_inv))));

endmodule

bind iocell_route iocell_route_chk u_chk (
    .eff_clk     (eff_clk),
    .rst_n       (rst_n),
    .cfg_latch   (cfg_latch),
    .cfg_in_path (cfg_in_path),
    .cfg_bypass  (cfg_bypass),
    .cfg_out_inv (cfg_out_inv),
    .pin_in      (pin_in),
    .mux_out     (mux_out),
    .store_q     (store_q),
    .pin_out     (pin_out),
    .fabric_fb   (fabric_fb)
);

// File: tb/test_iocell_route.sv
// Bench for the routed I/O cell: a behavioural reference model is compared
// with the pins in both phases of every bench clock.
module test_iocell_route;

    logic        clk = 1'b0;
    logic [31:0] cnt = '0;
    logic        rst_n = 1'b0;
    logic [3:0]  mux_data = '0;
    logic [1:0]  sel_src = '0;
    logic        pin_in = 1'b0;
    logic [3:0]  gclk;
    logic        route_clk;
    logic        route_oe = 1'b0;
    logic        cfg_latch = 1'b0, cfg_in_path = 1'b0, cfg_bypass = 1'b0;
    logic [2:0]  cfg_clk_src = '0;
    logic        cfg_clk_inv = 1'b0, cfg_sel0_src = 1'b0, cfg_sel1_src = 1'b1;
    logic        cfg_sel0_inv = 1'b0, cfg_sel1_inv = 1'b0;
    logic        cfg_out_inv = 1'b0, cfg_oe_inv = 1'b0;
    logic        pin_out, pin_oe, fabric_fb;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R11";

    always #5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;
    assign gclk      = {cnt[1], cnt[0], ~clk, clk};
    assign route_clk = (cnt % 3) == 0;

    iocell_route i_iocell_route (
        .rst_n (rst_n), .mux_data (mux_data), .sel_src (sel_src), .pin_in (pin_in),
        .gclk (gclk), .route_clk (route_clk), .route_oe (route_oe),
        .cfg_latch (cfg_latch), .cfg_in_path (cfg_in_path), .cfg_bypass (cfg_bypass),
        .cfg_clk_src (cfg_clk_src), .cfg_clk_inv (cfg_clk_inv),
        .cfg_sel0_src (cfg_sel0_src), .cfg_sel1_src (cfg_sel1_src),
        .cfg_sel0_inv (cfg_sel0_inv), .cfg_sel1_inv (cfg_sel1_inv),
        .cfg_out_inv (cfg_out_inv), .cfg_oe_inv (cfg_oe_inv),
        .pin_out (pin_out), .pin_oe (pin_oe), .fabric_fb (fabric_fb)
    );

    // ---------------- reference model ----------------
    logic m_s0, m_s1, m_mux, m_eff, m_d, m_q = 1'b0, m_prev = 1'b0;
    logic exp_out, exp_oe, exp_fb;

    always_comb begin
        m_s0 = (cfg_sel0_src ? sel_src[1] : sel_src[0]) ^ cfg_sel0_inv;
        m_s1 = (cfg_sel1_src ? sel_src[1] : sel_src[0]) ^ cfg_sel1_inv;
        if (!m_s1 && !m_s0)     m_mux = mux_data[0];
        else if (!m_s1 && m_s0) m_mux = mux_data[1];
        else if (m_s1 && m_s0)  m_mux = mux_data[2];
        else                    m_mux = mux_data[3];
        if (cfg_clk_src < 3'd4) m_eff = gclk[cfg_clk_src[1:0]] ^ cfg_clk_inv;
        else                    m_eff = route_clk ^ cfg_clk_inv;
        m_d = cfg_in_path ? pin_in : m_mux;
    end

    always @(m_eff or m_d or rst_n or cfg_latch) begin
        if (cfg_latch) begin
            if (m_eff) m_q = rst_n ? m_d : 1'b0;
        end else if (m_eff && !m_prev) begin
            m_q = rst_n ? m_d : 1'b0;
        end
        m_prev = m_eff;
    end

    always_comb begin
        exp_out = ((cfg_bypass || cfg_in_path) ? m_mux : m_q) ^ cfg_out_inv;
        exp_oe  = route_oe ^ cfg_oe_inv;
        exp_fb  = (cfg_in_path && !cfg_bypass) ? m_q : pin_in;
    end

    // ---------------- checking ----------------
    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        n_chk++;
        if (pin_out !== exp_out || pin_oe !== exp_oe || fabric_fb !== exp_fb) begin
            n_fail++;
            $display("FAIL %s out/oe/fb actual=%b%b%b expected=%b%b%b at %0t",
                     cur_tag, pin_out, pin_oe, fabric_fb, exp_out, exp_oe, exp_fb, $time);
        end
    endtask

    // Compare in both phases of every bench clock, away from all edges
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (cmp_on) compare_all();
            #5;
            if (cmp_on) compare_all();
        end
    end

    task automatic drive_random();
        @(posedge clk);
        #1;
        mux_data = 4'($urandom);
        sel_src  = 2'($urandom);
        pin_in   = 1'($urandom);
        route_oe = 1'($urandom);
    endtask

    // Reconfigure under reset, check the cleared state, then run random data
    task automatic run_case(input string tag, input logic lt, input logic ip, input logic bp,
                            input logic [2:0] cs, input logic ci, input logic s0s, input logic s1s,
                            input logic s0i, input logic s1i, input logic oi, input logic oei,
                            input int n);
        @(posedge clk);
        #1;
        cmp_on = 1'b0;
        cur_tag = tag;
        rst_n = 1'b0;
        cfg_latch = lt; cfg_in_path = ip; cfg_bypass = bp; cfg_clk_src = cs;
        cfg_clk_inv = ci; cfg_sel0_src = s0s; cfg_sel1_src = s1s;
        cfg_sel0_inv = s0i; cfg_sel1_inv = s1i; cfg_out_inv = oi; cfg_oe_inv = oei;
        repeat (8) @(posedge clk);
        #3;
        if (!ip && !bp) check_bit("R11", "pin_out in reset", pin_out, oi);
        cmp_on = 1'b1;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) drive_random();
    endtask

    // Directed R1 order check in bypass with direct selects
    task automatic gray_order();
        logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1;
            mux_data = 4'b0001 << k;
            sel_src  = codes[k];
            #2;
            check_bit("R1", "one-hot pick", pin_out, 1'b1);
            mux_data = ~(4'b0001 << k);
            #1;
            check_bit("R1", "zero pick", pin_out, 1'b0);
        end
    endtask

    initial begin
        repeat (8) @(posedge clk);
        #3;
        check_bit("R11", "reset pin_out", pin_out, 1'b0);
        check_bit("R4", "reset pin_oe", pin_oe, 1'b0);
        check_bit("R9", "reset fabric_fb", fabric_fb, pin_in);
        //        tag    lt ip bp cs    ci s0s s1s s0i s1i oi oei
        run_case("R1",  0, 0, 1, 3'd0, 0, 0, 1, 0, 0, 0, 0, 30);
        gray_order();
        run_case("R2",  0, 0, 1, 3'd0, 0, 1, 0, 1, 1, 0, 0, 30);
        run_case("R2",  0, 0, 1, 3'd0, 0, 0, 0, 0, 1, 0, 0, 30);
        run_case("R3",  0, 0, 1, 3'd0, 0, 0, 1, 0, 0, 1, 1, 30);
        run_case("R5",  0, 0, 0, 3'd0, 0, 0, 1, 0, 0, 0, 0, 40);
        run_case("R7",  0, 0, 0, 3'd1, 1, 0, 1, 0, 0, 0, 0, 30);
        run_case("R7",  0, 0, 0, 3'd2, 0, 1, 1, 0, 1, 1, 0, 30);
        run_case("R7",  0, 0, 0, 3'd3, 1, 0, 1, 0, 0, 0, 1, 30);
        run_case("R7",  0, 0, 0, 3'd4, 0, 0, 1, 0, 0, 0, 0, 30);
        run_case("R7",  0, 0, 0, 3'd7, 1, 0, 1, 0, 0, 0, 0, 30);
        run_case("R6",  1, 0, 0, 3'd0, 0, 0, 1, 0, 0, 0, 0, 30);
        run_case("R6",  1, 0, 0, 3'd3, 1, 1, 0, 0, 0, 1, 0, 30);
        run_case("R8",  0, 1, 0, 3'd2, 0, 0, 1, 0, 0, 0, 0, 30);
        run_case("R8",  1, 1, 0, 3'd5, 0, 0, 1, 1, 0, 1, 1, 30);
        run_case("R9",  0, 0, 0, 3'd1, 0, 0, 1, 0, 0, 1, 0, 30);
        run_case("R10", 0, 1, 1, 3'd0, 0, 0, 1, 0, 0, 0, 0, 30);
        run_case("R11", 0, 0, 0, 3'd0, 0, 0, 1, 0, 0, 0, 0, 10);
        // R11: reset asserted in the middle of a register run
        @(posedge clk);
        #1;
        mux_data = 4'hF;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        check_bit("R11", "cleared mid-run", pin_out, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        drive_random();
        drive_random();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R) actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule